// File: doc/BRIEF.md
# Four-Channel DMA Register Front End

This block holds the programming state of a four-channel DMA controller and exposes it to a host through 8-bit bus ports. Each channel keeps a 16-bit base and current address, a 16-bit base and current count, an 8-bit page register that supplies the upper address bits, a mode byte and a mask bit. One shared byte-pointer flip-flop decides whether an access to any 16-bit register reaches its low or its high byte. A host clears the pointer, writes the start address and the length minus one, low byte first, sets the page and mode, and then unmasks the channel.

A simple transfer-request input stands in for the data path. Each accepted request on an unmasked, non-cascade channel produces one acknowledge carrying the physical address of that transfer. It then moves the address up by one and the count down by one. When the count underflows, the channel flags terminal count and then either reloads from its base values (autoinitialise) or masks itself. The `WORD_MODE` parameter doubles the port stride and treats the address register as a word address, so the emitted physical address is the register shifted left by one under the page.

Top module: `dma_regfile_top`

## Requirements
- R1: After reset all four channels are masked, the byte pointer selects the low byte, `bus_rdata` is 0 and `xfer_ack` and `xfer_tc` are low.
- R2: Any write to the clear-pointer port points the byte pointer at the low byte. Every read or write of an address or count port flips the pointer, so two accesses in a row reach the low and then the high byte.
- R3: Port offsets are multiples of a stride S (1 in byte mode, 2 in word mode): channel c address at 2c·S, count at (2c+1)·S, single-mask at 10·S, mode at 11·S, clear-pointer at 12·S, and page of channel c at (16+c)·S. Reads of address and count return the current values; a page read returns the page byte; other reads return 0.
- R4: A single-mask write uses data bits [1:0] as the channel and bit 2 as the new mask value (1 masked, 0 enabled).
- R5: A channel programmed with count N performs N+1 transfers. Each accepted request raises `xfer_ack` for one cycle in the next cycle with the pre-increment address, and the current address then goes up by one.
- R6: On the transfer that finds the count at zero, `xfer_tc` pulses with the acknowledge. A channel in single mode (mode bit 4 clear) then masks itself and its count reads back as 0xFFFF.
- R7: On terminal count, a channel in autoinitialise mode (mode bit 4 set) reloads the current address and count from the base values and stays unmasked.
- R8: The page register does not change when the address counter wraps from 0xFFFF to 0x0000. In byte mode `xfer_addr` is {page, current address}.
- R9: In word mode `xfer_addr` is {page[7:1], current address, 0}.
- R10: Mode bits [1:0] select the channel being written, and mode bit 2 is reported on `xfer_write` with each acknowledge. A channel whose mode bits [7:6] are 11 (cascade) ignores transfer requests.
- R11: A request to a masked channel produces no acknowledge and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | PA_W | Port offset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after `bus_rd` |
| xfer_req | input | 1 | Request one transfer on `xfer_ch` |
| xfer_ch | input | CH_W | Requesting channel |
| xfer_ack | output | 1 | Transfer accepted (registered) |
| xfer_write | output | 1 | Direction bit of the acknowledged channel |
| xfer_tc | output | 1 | Acknowledged transfer reached terminal count |
| xfer_addr | output | 24 | Physical address of the acknowledged transfer |
| ch_masked | output | NCH | Mask bit per channel |

## Verification
All results are due one edge after their cause. A write changes `ch_masked` and the register contents at that edge, a read's byte appears on `bus_rdata` at that edge, and a request's acknowledge, address and terminal-count flag are registered at that same edge. The bench model applies each stimulus at the same rising edge the design does, and it compares all outputs on the following falling edge. Stimulus changes just after a rising edge, so every comparison sees settled values from exactly one step. A byte-mode and a word-mode instance share the same logical stimulus, so one model state predicts both address forms.

// File: rtl/dma_regfile_pkg.sv
package dma_regfile_pkg;
  typedef enum logic [2:0] {
    K_NONE, K_ADDR, K_CNT, K_MASK, K_MODE, K_CLR, K_PAGE
  } port_kind_e;

  localparam int MODE_DIR_BIT  = 2;
  localparam int MODE_AUTO_BIT = 4;
  localparam int MASK_VAL_BIT  = 2;
  localparam logic [1:0] MODE_CASCADE = 2'b11;
  localparam int MASK_PORT  = 10;
  localparam int MODE_PORT  = 11;
  localparam int CLR_PORT   = 12;
  localparam int PAGE_BASE  = 16;
endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode
  import dma_regfile_pkg::*;
#(
  parameter int PA_W   = 6,
  parameter int NCH    = 4,
  parameter int STRIDE = 1,
  localparam int CH_W  = $clog2(NCH)
) (
  input  logic [PA_W-1:0] addr,
  output port_kind_e      kind,
  output logic [CH_W-1:0] ch
);
  localparam int SH = (STRIDE == 2) ? 1 : 0;

  logic [PA_W-1:0] idx;
  logic            aligned;

  assign idx     = addr >> SH;
  assign aligned = (SH == 0) || (addr[0] == 1'b0);

  always_comb begin
    kind = K_NONE;
    ch   = '0;
    if (aligned) begin
      if (idx < PA_W'(2 * NCH)) begin
        kind = idx[0] ? K_CNT : K_ADDR;
        ch   = idx[CH_W:1];
      end else if (idx == PA_W'(MASK_PORT)) begin
        kind = K_MASK;
      end else if (idx == PA_W'(MODE_PORT)) begin
        kind = K_MODE;
      end else if (idx == PA_W'(CLR_PORT)) begin
        kind = K_CLR;
      end else if (idx >= PA_W'(PAGE_BASE) && idx < PA_W'(PAGE_BASE + NCH)) begin
        kind = K_PAGE;
        ch   = idx[CH_W-1:0];
      end
    end
  end
endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_regfile_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hi_byte,
  input  logic [7:0]    wdata,
  input  logic          wr_addr,
  input  logic          wr_cnt,
  input  logic          wr_page,
  input  logic          wr_mode,
  input  logic          mask_we,
  input  logic          mask_d,
  input  logic          step,
  output logic [CW-1:0] cur_addr,
  output logic [CW-1:0] cur_cnt,
  output logic [7:0]    page,
  output logic [7:0]    mode,
  output logic          masked,
  output logic          tc
);
  logic [CW-1:0] base_addr, base_cnt;
  logic          auto_mode;

  assign auto_mode = mode[MODE_AUTO_BIT];
  assign tc        = step && (cur_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      cur_addr  <= '0;
      base_cnt  <= '0;
      cur_cnt   <= '0;
      page      <= '0;
      mode      <= '0;
      masked    <= 1'b1;
    end else begin
      if (wr_addr) begin
        if (hi_byte) begin
          base_addr[CW-1:8] <= wdata;
          cur_addr[CW-1:8]  <= wdata;
        end else begin
          base_addr[7:0] <= wdata;
          cur_addr[7:0]  <= wdata;
        end
      end
      if (wr_cnt) begin
        if (hi_byte) begin
          base_cnt[CW-1:8] <= wdata;
          cur_cnt[CW-1:8]  <= wdata;
        end else begin
          base_cnt[7:0] <= wdata;
          cur_cnt[7:0]  <= wdata;
        end
      end
      if (wr_page) page <= wdata;
      if (wr_mode) mode <= wdata;
      if (mask_we) masked <= mask_d;
      if (step) begin
        if (tc && auto_mode) begin
          cur_addr <= base_addr;
          cur_cnt  <= base_cnt;
        end else begin
          cur_addr <= cur_addr + 1'b1;
          cur_cnt  <= cur_cnt - 1'b1;
          if (tc) masked <= 1'b1;
        end
      end
    end
  end

  p_single_tc_masks_r6: assert property (@(posedge clk) disable iff (rst)
    (tc && !auto_mode) |=> (masked && cur_cnt == '1));
  p_auto_tc_reloads_r7: assert property (@(posedge clk) disable iff (rst)
    (tc && auto_mode && !mask_we && !wr_cnt) |=> (!masked && cur_cnt == $past(base_cnt)));
  p_page_holds_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_page |=> $stable(page));
endmodule

// File: rtl/dma_regfile_top.sv
module dma_regfile_top
  import dma_regfile_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int WORD_MODE = 0,
  parameter int PA_W      = 6,
  localparam int CH_W     = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PA_W-1:0] bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  input  logic            xfer_req,
  input  logic [CH_W-1:0] xfer_ch,
  output logic            xfer_ack,
  output logic            xfer_write,
  output logic            xfer_tc,
  output logic [23:0]     xfer_addr,
  output logic [NCH-1:0]  ch_masked
);
  localparam int STRIDE = (WORD_MODE != 0) ? 2 : 1;

  port_kind_e      kind;
  logic [CH_W-1:0] sel_ch;
  logic            hi_ff;
  logic            acc16;
  logic            clr_wr;

  logic [15:0]    cur_a [NCH];
  logic [15:0]    cur_c [NCH];
  logic [7:0]     pg    [NCH];
  logic [7:0]     md    [NCH];
  logic [NCH-1:0] step, tc;

  dma_port_decode #(.PA_W(PA_W), .NCH(NCH), .STRIDE(STRIDE)) u_dec (
    .addr(bus_addr), .kind(kind), .ch(sel_ch)
  );

  assign acc16  = (bus_wr || bus_rd) && (kind == K_ADDR || kind == K_CNT);
  assign clr_wr = bus_wr && (kind == K_CLR);

  always_ff @(posedge clk) begin
    if (rst)         hi_ff <= 1'b0;
    else if (clr_wr) hi_ff <= 1'b0;
    else if (acc16)  hi_ff <= ~hi_ff;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit     = (sel_ch == CH_W'(i));
    assign step[i] = xfer_req && (xfer_ch == CH_W'(i)) && !ch_masked[i]
                     && (md[i][7:6] != MODE_CASCADE);

    dma_channel #(.CW(16)) u_ch (
      .clk(clk), .rst(rst), .hi_byte(hi_ff), .wdata(bus_wdata),
      .wr_addr(bus_wr && kind == K_ADDR && hit),
      .wr_cnt (bus_wr && kind == K_CNT  && hit),
      .wr_page(bus_wr && kind == K_PAGE && hit),
      .wr_mode(bus_wr && kind == K_MODE && bus_wdata[CH_W-1:0] == CH_W'(i)),
      .mask_we(bus_wr && kind == K_MASK && bus_wdata[CH_W-1:0] == CH_W'(i)),
      .mask_d (bus_wdata[MASK_VAL_BIT]),
      .step(step[i]),
      .cur_addr(cur_a[i]), .cur_cnt(cur_c[i]), .page(pg[i]), .mode(md[i]),
      .masked(ch_masked[i]), .tc(tc[i])
    );
  end

  logic [23:0] phys;
  if (WORD_MODE != 0) begin : g_word
    assign phys = {pg[xfer_ch][7:1], cur_a[xfer_ch], 1'b0};
  end else begin : g_byte
    assign phys = {pg[xfer_ch], cur_a[xfer_ch]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_ack   <= 1'b0;
      xfer_tc    <= 1'b0;
      xfer_write <= 1'b0;
      xfer_addr  <= '0;
      bus_rdata  <= '0;
    end else begin
      xfer_ack <= |step;
      xfer_tc  <= |tc;
      if (|step) begin
        xfer_addr  <= phys;
        xfer_write <= md[xfer_ch][MODE_DIR_BIT];
      end
      bus_rdata <= '0;
      if (bus_rd) begin
        unique case (kind)
          K_ADDR:  bus_rdata <= hi_ff ? cur_a[sel_ch][15:8] : cur_a[sel_ch][7:0];
          K_CNT:   bus_rdata <= hi_ff ? cur_c[sel_ch][15:8] : cur_c[sel_ch][7:0];
          K_PAGE:  bus_rdata <= pg[sel_ch];
          default: bus_rdata <= '0;
        endcase
      end
    end
  end

  p_clear_ptr_r2: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> !hi_ff);
  p_ptr_toggles_r2: assert property (@(posedge clk) disable iff (rst)
    (acc16 && !clr_wr) |=> (hi_ff != $past(hi_ff)));
  p_ack_has_req_r5: assert property (@(posedge clk) disable iff (rst)
    xfer_ack |-> $past(xfer_req));
  p_masked_ignored_r11: assert property (@(posedge clk) disable iff (rst)
    (xfer_req && ch_masked[xfer_ch]) |=> !xfer_ack);
  p_tc_with_ack_r6: assert property (@(posedge clk) disable iff (rst)
    xfer_tc |-> xfer_ack);
endmodule

// File: tb/dma_regfile_top_tb_top.sv
module dma_regfile_top_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1;
  int         b_idx = 0;
  logic       b_wr = 0, b_rd = 0, b_req = 0;
  logic [7:0] b_wdata = 0;
  logic [1:0] b_ch = 0;

  logic [7:0]  rd_b, rd_w;
  logic        ack_b, ack_w, wrd_b, wrd_w, tc_b, tc_w;
  logic [23:0] ad_b, ad_w;
  logic [3:0]  msk_b, msk_w;

  dma_regfile_top #(.WORD_MODE(0)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(6'(b_idx)), .bus_wr(b_wr), .bus_rd(b_rd),
    .bus_wdata(b_wdata), .bus_rdata(rd_b), .xfer_req(b_req), .xfer_ch(b_ch),
    .xfer_ack(ack_b), .xfer_write(wrd_b), .xfer_tc(tc_b), .xfer_addr(ad_b),
    .ch_masked(msk_b));

  dma_regfile_top #(.WORD_MODE(1)) dut_w (
    .clk(clk), .rst(rst), .bus_addr(6'(b_idx * 2)), .bus_wr(b_wr), .bus_rd(b_rd),
    .bus_wdata(b_wdata), .bus_rdata(rd_w), .xfer_req(b_req), .xfer_ch(b_ch),
    .xfer_ack(ack_w), .xfer_write(wrd_w), .xfer_tc(tc_w), .xfer_addr(ad_w),
    .ch_masked(msk_w));

  int errs = 0, checks = 0;

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference state
  int m_ba[4], m_ca[4], m_bc[4], m_cc[4], m_pg[4], m_md[4];
  bit m_mask[4];
  bit m_ff;
  bit e_ack, e_tc, e_dir;
  int e_rd, e_ab, e_aw;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_ba[i]) begin
        m_ba[i] = 0; m_ca[i] = 0; m_bc[i] = 0; m_cc[i] = 0;
        m_pg[i] = 0; m_md[i] = 0; m_mask[i] = 1;
      end
      m_ff = 0; e_ack = 0; e_tc = 0; e_rd = 0; e_dir = 0; e_ab = 0; e_aw = 0;
    end else begin
      int c;
      int v;
      int sh;
      e_rd = 0;
      e_ack = 0;
      e_tc = 0;
      sh = m_ff ? 8 : 0;
      if (b_rd) begin
        if (b_idx < 8) begin
          c = b_idx / 2;
          v = (b_idx % 2) ? m_cc[c] : m_ca[c];
          e_rd = (v >> sh) & 255;
        end else if (b_idx >= 16 && b_idx < 20) e_rd = m_pg[b_idx - 16];
      end
      c = b_ch;
      if (b_req && !m_mask[c] && ((m_md[c] >> 6) != 3)) begin
        e_ack = 1;
        e_dir = m_md[c][2];
        e_ab = (m_pg[c] << 16) | m_ca[c];
        e_aw = ((m_pg[c] >> 1) << 17) | (m_ca[c] << 1);
        if (m_cc[c] == 0) begin
          e_tc = 1;
          if (m_md[c][4]) begin m_ca[c] = m_ba[c]; m_cc[c] = m_bc[c]; end
          else begin m_ca[c] = (m_ca[c] + 1) & 16'hFFFF; m_cc[c] = 16'hFFFF; m_mask[c] = 1; end
        end else begin
          m_ca[c] = (m_ca[c] + 1) & 16'hFFFF;
          m_cc[c] = m_cc[c] - 1;
        end
      end
      if (b_wr) begin
        if (b_idx < 8) begin
          c = b_idx / 2;
          if (b_idx % 2) begin
            m_bc[c] = (m_bc[c] & ~(255 << sh)) | (int'(b_wdata) << sh);
            m_cc[c] = (m_cc[c] & ~(255 << sh)) | (int'(b_wdata) << sh);
          end else begin
            m_ba[c] = (m_ba[c] & ~(255 << sh)) | (int'(b_wdata) << sh);
            m_ca[c] = (m_ca[c] & ~(255 << sh)) | (int'(b_wdata) << sh);
          end
        end else if (b_idx == 10) m_mask[b_wdata[1:0]] = b_wdata[2];
        else if (b_idx == 11) m_md[b_wdata[1:0]] = b_wdata;
        else if (b_idx == 12) m_ff = 0;
        else if (b_idx >= 16 && b_idx < 20) m_pg[b_idx - 16] = b_wdata;
      end
      if ((b_rd || b_wr) && b_idx < 8) m_ff = ~m_ff;
    end
  end

  // per-cycle comparison, half a period after each edge
  always @(negedge clk) begin
    if (!rst) begin
      check("R3 rdata byte", rd_b, e_rd);
      check("R3 rdata word", rd_w, e_rd);
      check("R5 ack", ack_b, e_ack);
      check("R9 ack word", ack_w, e_ack);
      check("R6 tc", tc_b, e_tc);
      check("R4 mask byte", msk_b, {m_mask[3], m_mask[2], m_mask[1], m_mask[0]});
      check("R4 mask word", msk_w, {m_mask[3], m_mask[2], m_mask[1], m_mask[0]});
      if (e_ack) begin
        check("R8 addr byte", ad_b, e_ab);
        check("R9 addr word", ad_w, e_aw);
        check("R10 dir", wrd_b, e_dir);
      end
    end
  end

  task automatic wr(int idx, logic [7:0] d);
    @(posedge clk); #1;
    b_idx = idx; b_wdata = d; b_wr = 1;
    @(posedge clk); #1;
    b_wr = 0;
  endtask

  task automatic rd(int idx, output logic [7:0] d);
    @(posedge clk); #1;
    b_idx = idx; b_rd = 1;
    @(posedge clk); #1;
    b_rd = 0;
    @(negedge clk);
    d = rd_b;
  endtask

  task automatic req(logic [1:0] ch);
    @(posedge clk); #1;
    b_ch = ch; b_req = 1;
    @(posedge clk); #1;
    b_req = 0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [7:0] lo, hi;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check("R1 masks", msk_b, 4'hF);
    check("R1 rdata", rd_b, 0);
    check("R1 ack", ack_b, 0);
    check("R1 tc", tc_b, 0);

    // channel 1 single mode, 3 transfers, dir bit set
    wr(12, 8'h00);
    wr(2, 8'h34); wr(2, 8'h12);
    wr(3, 8'h02); wr(3, 8'h00);
    wr(17, 8'h56);
    wr(11, 8'h45);
    wr(10, 8'h01);
    check("R4 unmask ch1", msk_b, 4'b1101);
    wr(12, 8'h00);
    rd(2, lo); rd(2, hi);
    check("R2 addr low byte", lo, 8'h34);
    check("R2 addr high byte", hi, 8'h12);
    rd(17, lo);
    check("R3 page readback", lo, 8'h56);
    req(2'd1);
    check("R5 first ack", ack_b, 1);
    check("R5 first addr", ad_b, 24'h561234);
    check("R10 dir bit", wrd_b, 1);
    req(2'd1);
    check("R5 second addr", ad_b, 24'h561235);
    check("R6 no early tc", tc_b, 0);
    req(2'd1);
    check("R6 tc on third", tc_b, 1);
    check("R9 word addr", ad_w, 24'h56246C);
    check("R6 self masked", msk_b[1], 1);
    wr(12, 8'h00);
    rd(3, lo); rd(3, hi);
    check("R6 count low after tc", lo, 8'hFF);
    check("R6 count high after tc", hi, 8'hFF);
    req(2'd1);
    check("R11 masked no ack", ack_b, 0);

    // channel 2 autoinitialise, 3 transfers across wrap
    wr(12, 8'h00);
    wr(4, 8'hFE); wr(4, 8'hFF);
    wr(5, 8'h02); wr(5, 8'h00);
    wr(18, 8'h07);
    wr(11, 8'h52);
    wr(10, 8'h02);
    req(2'd2); req(2'd2); req(2'd2);
    check("R8 wrap keeps page", ad_b, 24'h070000);
    check("R7 tc pulse", tc_b, 1);
    check("R7 stays unmasked", msk_b[2], 0);
    req(2'd2);
    check("R7 reload addr", ad_b, 24'h07FFFE);

    // channel 3 cascade ignores requests
    wr(11, 8'hC3);
    wr(10, 8'h03);
    req(2'd3);
    check("R10 cascade no ack", ack_b, 0);

    // pointer toggles across a lone low write
    wr(12, 8'h00);
    wr(0, 8'hAA);
    rd(0, lo);
    check("R2 toggle to high", lo, 8'h00);
    rd(0, lo);
    check("R2 toggle back low", lo, 8'hAA);
    wr(10, 8'h06);
    check("R4 remask ch2", msk_b[2], 1);

    repeat (3) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule